// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block watches for missed software refreshes against a free-running external system counter. Software writes a period length into an offset register. Each refresh sets a deadline equal to the current counter value plus that offset. If the counter reaches the deadline while the timer is enabled, a first-stage flag rises. That flag is meant to drive an interrupt line. A second period of the same length then begins. If it also runs out without a refresh, a second-stage flag rises. That flag is meant to request a system reset.

Access is through two independent 32-bit register ports. The refresh port has a single kick register; any write to it restarts the period. The control port holds the following registers:

- the enable and status word;
- the period offset;
- the deadline, split into 32-bit words;
- two identification words, which the refresh port also exposes.

The second-stage flag is cleared only by the power-on reset input or by a refresh. It therefore stays readable after the system reset it caused. The counter source, interrupt and reset controllers, and all timeout policy stay outside the block.

Top module: `twostage_wdog`

## Requirements
- R1: After power-on reset both stage outputs are 0, and the control word, offset and every deadline word read as 0.
- R2: A write to refresh-port address 0x000 is a refresh. A refresh clears both stage flags and loads the deadline with the current counter value plus the zero-extended offset.
- R3: A write to control address 0x000 is a refresh. It also loads the enable bit from data bit 0. Writing 0 there stops the timer, and no stage flag rises afterwards, even when the counter passes the deadline.
- R4: A write to control address 0x008 stores a new offset and refreshes using that new value. The deadline sum carries across 32-bit word boundaries.
- R5: While enabled and with the first-stage flag clear, a counter value at or above the deadline sets the first-stage flag one clock later. The same event reloads the deadline to the counter plus the offset.
- R6: While enabled and with the first-stage flag set, a counter at or above the deadline sets the second-stage flag. That flag stays set until a refresh or a power-on reset.
- R7: Control address 0x000 reads back bit 0 = enable, bit 1 = first-stage flag, bit 2 = second-stage flag. Address 0x008 reads the offset. Deadline word i reads at 0x010 + 4*i, with the low word first.
- R8: A write to a deadline word replaces that word and leaves both stage flags unchanged.
- R9: Both ports return the interface identification parameter at 0xFCC and the block identification parameter at 0xFD0. Any unmapped address reads 0.
- R10: While the enable bit is 0, neither stage flag rises.
- R11: The second-stage flag is never set while the first-stage flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset; the only reset of the flags |
| sys_cnt | input | CNT_W | Free-running system counter value |
| rf_wr | input | 1 | Refresh port write strobe |
| rf_addr | input | ADDR_W | Refresh port byte address |
| rf_rdata | output | 32 | Refresh port read data (combinational) |
| cf_wr | input | 1 | Control port write strobe |
| cf_addr | input | ADDR_W | Control port byte address |
| cf_wdata | input | 32 | Control port write data |
| cf_rdata | output | 32 | Control port read data (combinational) |
| stage1_o | output | 1 | First-stage timeout (interrupt request) |
| stage2_o | output | 1 | Second-stage timeout (reset request) |

## Verification
The assertions check several properties on every cycle:

- the ordering of the two flags;
- that a refresh clears both flags;
- that the second-stage flag stays sticky;
- that no flag rises while the timer is disabled;
- that every flag rise follows an expired deadline;
- that a direct deadline write lands in the register.

Only the bench scenarios can show the exact cycle of each escalation relative to the offset, which is swept over several lengths. The same holds for reloading from a newly written offset, carry into the upper deadline word, identification readback, and the flag clearing by power-on reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned OFF_KICK    = 'h000;
   localparam int unsigned OFF_CTRL    = 'h000;
   localparam int unsigned OFF_PERIOD  = 'h008;
   localparam int unsigned OFF_DL_BASE = 'h010;
   localparam int unsigned OFF_IFID    = 'hFCC;
   localparam int unsigned OFF_BLKID   = 'hFD0;
   localparam int unsigned BIT_EN      = 0;
   localparam int unsigned BIT_ST1     = 1;
   localparam int unsigned BIT_ST2     = 2;
endpackage

// File: rtl/wdog_deadline.sv
module wdog_deadline #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned OFS_W = 32,
   localparam int unsigned NW   = CNT_W / 32
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [OFS_W-1:0] ofs,
   input  logic             reload,
   input  logic [NW-1:0]    wr_word,
   input  logic [31:0]      wdata,
   output logic [CNT_W-1:0] cmp,
   output logic             due
);
   logic [CNT_W-1:0] next_dl;

   assign next_dl = cnt + {{(CNT_W-OFS_W){1'b0}}, ofs};
   assign due     = cnt >= cmp;

   for (genvar w = 0; w < NW; w++) begin : g_word
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)          cmp[w*32 +: 32] <= '0;
         else if (wr_word[w]) cmp[w*32 +: 32] <= wdata;
         else if (reload)     cmp[w*32 +: 32] <= next_dl[w*32 +: 32];
      end
   end

   a_r8_word_write: assert property (@(posedge clk) disable iff (!por_n)
      wr_word[0] |=> cmp[31:0] == $past(wdata));
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
   input  logic clk,
   input  logic por_n,
   input  logic refresh,
   input  logic en,
   input  logic due,
   output logic ws0,
   output logic ws1,
   output logic advance
);
   logic escalate;

   assign advance  = en && due && !ws0 && !refresh;
   assign escalate = en && due && ws0 && !ws1 && !refresh;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ws0 <= 1'b0;
         ws1 <= 1'b0;
      end else if (refresh) begin
         ws0 <= 1'b0;
         ws1 <= 1'b0;
      end else begin
         if (advance)  ws0 <= 1'b1;
         if (escalate) ws1 <= 1'b1;
      end
   end

   a_r11_order: assert property (@(posedge clk) disable iff (!por_n)
      ws1 |-> ws0);
   a_r2_refresh_clears: assert property (@(posedge clk) disable iff (!por_n)
      refresh |=> (!ws0 && !ws1));
   a_r6_sticky: assert property (@(posedge clk) disable iff (!por_n)
      (ws1 && !refresh) |=> ws1);
   a_r10_no_rise_off: assert property (@(posedge clk) disable iff (!por_n)
      ($rose(ws0) || $rose(ws1)) |-> $past(en));
   a_r5_rise_on_due: assert property (@(posedge clk) disable iff (!por_n)
      ($rose(ws0) || $rose(ws1)) |-> $past(due));
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned CNT_W    = 64,
   parameter int unsigned OFS_W    = 32,
   parameter logic [31:0] IFACE_ID = 32'h0000_0A17,
   parameter logic [31:0] BLOCK_ID = 32'h0005_1D02
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [CNT_W-1:0]  sys_cnt,
   input  logic              rf_wr,
   input  logic [ADDR_W-1:0] rf_addr,
   output logic [31:0]       rf_rdata,
   input  logic              cf_wr,
   input  logic [ADDR_W-1:0] cf_addr,
   input  logic [31:0]       cf_wdata,
   output logic [31:0]       cf_rdata,
   output logic              stage1_o,
   output logic              stage2_o
);
   localparam int unsigned NW = CNT_W / WORD_W;

   if (CNT_W % WORD_W != 0 || CNT_W <= OFS_W) begin : g_bad_cnt
      $error("CNT_W must be a multiple of 32 and wider than OFS_W");
   end
   if (OFS_W == 0 || OFS_W > WORD_W) begin : g_bad_ofs
      $error("OFS_W must lie in 1..32");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must reach the identification registers");
   end

   logic             ctrl_wr, period_wr, kick_wr, refresh;
   logic [NW-1:0]    dl_wr;
   logic             en_q;
   logic [OFS_W-1:0] ofs_q, ofs_eff;
   logic [CNT_W-1:0] dl;
   logic             due, ws0, ws1, advance;

   assign kick_wr   = rf_wr && (rf_addr == ADDR_W'(OFF_KICK));
   assign ctrl_wr   = cf_wr && (cf_addr == ADDR_W'(OFF_CTRL));
   assign period_wr = cf_wr && (cf_addr == ADDR_W'(OFF_PERIOD));
   assign refresh   = kick_wr || ctrl_wr || period_wr;

   for (genvar i = 0; i < NW; i++) begin : g_dl_dec
      assign dl_wr[i] = cf_wr && (cf_addr == ADDR_W'(OFF_DL_BASE + 4*i));
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         en_q  <= 1'b0;
         ofs_q <= '0;
      end else begin
         if (ctrl_wr)   en_q  <= cf_wdata[BIT_EN];
         if (period_wr) ofs_q <= OFS_W'(cf_wdata);
      end
   end

   assign ofs_eff = period_wr ? OFS_W'(cf_wdata) : ofs_q;

   wdog_deadline #(.CNT_W(CNT_W), .OFS_W(OFS_W)) deadline_i (
      .clk(clk), .por_n(por_n), .cnt(sys_cnt), .ofs(ofs_eff),
      .reload(refresh || advance), .wr_word(dl_wr), .wdata(cf_wdata),
      .cmp(dl), .due(due));

   wdog_stage stage_i (
      .clk(clk), .por_n(por_n), .refresh(refresh), .en(en_q), .due(due),
      .ws0(ws0), .ws1(ws1), .advance(advance));

   assign stage1_o = ws0;
   assign stage2_o = ws1;

   always_comb begin
      rf_rdata = '0;
      if (rf_addr == ADDR_W'(OFF_IFID))       rf_rdata = IFACE_ID;
      else if (rf_addr == ADDR_W'(OFF_BLKID)) rf_rdata = BLOCK_ID;
   end

   always_comb begin
      cf_rdata = '0;
      if (cf_addr == ADDR_W'(OFF_CTRL)) begin
         cf_rdata[BIT_EN]  = en_q;
         cf_rdata[BIT_ST1] = ws0;
         cf_rdata[BIT_ST2] = ws1;
      end else if (cf_addr == ADDR_W'(OFF_PERIOD)) cf_rdata = 32'(ofs_q);
      else if (cf_addr == ADDR_W'(OFF_IFID))       cf_rdata = IFACE_ID;
      else if (cf_addr == ADDR_W'(OFF_BLKID))      cf_rdata = BLOCK_ID;
      for (int i = 0; i < NW; i++) begin
         if (cf_addr == ADDR_W'(OFF_DL_BASE + 4*i)) cf_rdata = dl[i*32 +: 32];
      end
   end

   a_r3_stop_holds: assert property (@(posedge clk) disable iff (!por_n)
      (ctrl_wr && !cf_wdata[BIT_EN]) |=> (!en_q && !stage1_o && !stage2_o));
endmodule

// File: tb/twostage_wdog_tb.sv
module twostage_wdog_tb_top;
   localparam logic [31:0] IFID = 32'h0000_0A17;
   localparam logic [31:0] BKID = 32'h0005_1D02;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic [63:0] cnt = '0;
   logic        rf_wr = 1'b0, cf_wr = 1'b0;
   logic [11:0] rf_addr = '0, cf_addr = '0;
   logic [31:0] cf_wdata = '0, rf_rdata, cf_rdata;
   logic        stage1_o, stage2_o;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   twostage_wdog dut_i (
      .clk(clk), .por_n(por_n), .sys_cnt(cnt),
      .rf_wr(rf_wr), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
      .cf_wr(cf_wr), .cf_addr(cf_addr), .cf_wdata(cf_wdata), .cf_rdata(cf_rdata),
      .stage1_o(stage1_o), .stage2_o(stage2_o));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cwr(input logic [11:0] a, input logic [31:0] d);
      cf_wr = 1'b1; cf_addr = a; cf_wdata = d;
      @(negedge clk);
      cf_wr = 1'b0;
   endtask

   task automatic kick(input logic [11:0] a);
      rf_wr = 1'b1; rf_addr = a;
      @(negedge clk);
      rf_wr = 1'b0;
   endtask

   task automatic crd(input logic [11:0] a, output logic [31:0] d);
      cf_addr = a; #1; d = cf_rdata;
   endtask

   task automatic rrd(input logic [11:0] a, output logic [31:0] d);
      rf_addr = a; #1; d = rf_rdata;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         cnt = cnt + 1;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [63:0] c;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 stage1", stage1_o, 0);
      chk("R1 stage2", stage2_o, 0);
      crd(12'h000, d); chk("R1 ctrl", d, 0);
      crd(12'h008, d); chk("R1 offset", d, 0);
      crd(12'h010, d); chk("R1 dl lo", d, 0);
      crd(12'h014, d); chk("R1 dl hi", d, 0);
      // R9 identification and unmapped
      crd(12'hFCC, d); chk("R9 cf ifid", d, IFID);
      crd(12'hFD0, d); chk("R9 cf blkid", d, BKID);
      rrd(12'hFCC, d); chk("R9 rf ifid", d, IFID);
      rrd(12'hFD0, d); chk("R9 rf blkid", d, BKID);
      crd(12'h004, d); chk("R9 unmapped", d, 0);
      rrd(12'h000, d); chk("R9 rf kick reads 0", d, 0);
      // R4 offset write refreshes with new offset
      cnt = 1000;
      cwr(12'h008, 5);
      crd(12'h010, d); chk("R4 dl after offset", d, 1005);
      crd(12'h008, d); chk("R7 offset read", d, 5);
      // R10 disabled past deadline
      tick(10);
      chk("R10 stage1 off", stage1_o, 0);
      chk("R10 stage2 off", stage2_o, 0);
      // R8 upper deadline word
      cwr(12'h014, 7);
      crd(12'h014, d); chk("R8 dl hi write", d, 7);
      // R3 enable refreshes
      cwr(12'h000, 1);
      crd(12'h000, d); chk("R3 ctrl enable", d, 1);
      crd(12'h010, d); chk("R3 dl lo", d, 1015);
      crd(12'h014, d); chk("R3 dl hi", d, 0);
      tick(4);
      chk("R5 before deadline", stage1_o, 0);
      tick(1);
      chk("R5 stage1 at deadline", stage1_o, 1);
      chk("R11 stage2 still low", stage2_o, 0);
      crd(12'h010, d); chk("R5 dl reloaded", d, 1020);
      crd(12'h000, d); chk("R7 ctrl st1", d, 3);
      tick(4);
      chk("R6 before 2nd deadline", stage2_o, 0);
      tick(1);
      chk("R6 stage2 at deadline", stage2_o, 1);
      crd(12'h000, d); chk("R7 ctrl st2", d, 7);
      tick(10);
      chk("R6 sticky", stage2_o, 1);
      // R2 refresh port, any data
      kick(12'h000);
      chk("R2 stage1 clear", stage1_o, 0);
      chk("R2 stage2 clear", stage2_o, 0);
      crd(12'h010, d); chk("R2 dl", d, 1035);
      // R8 direct write keeps flags
      tick(5);
      chk("R5 stage1 again", stage1_o, 1);
      cwr(12'h010, 2000);
      chk("R8 flag kept", stage1_o, 1);
      crd(12'h010, d); chk("R8 dl lo", d, 2000);
      cnt = 1999; @(negedge clk);
      chk("R8 no stage2 early", stage2_o, 0);
      cnt = 2000; @(negedge clk);
      chk("R8 stage2 at new dl", stage2_o, 1);
      // R3 stop
      cwr(12'h000, 0);
      chk("R3 stop clears st1", stage1_o, 0);
      chk("R3 stop clears st2", stage2_o, 0);
      cnt = 3000; repeat (3) @(negedge clk);
      chk("R3 stopped st1", stage1_o, 0);
      crd(12'h000, d); chk("R3 ctrl zero", d, 0);
      // R4 offset change while running
      cwr(12'h000, 1);
      tick(2);
      cwr(12'h008, 9);
      tick(8);
      chk("R4 not yet", stage1_o, 0);
      tick(1);
      chk("R4 new offset expiry", stage1_o, 1);
      tick(9);
      chk("R6 second stage", stage2_o, 1);
      // R6 power-on reset clears
      por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
      chk("R6 por clears st2", stage2_o, 0);
      crd(12'h000, d); chk("R1 ctrl after por", d, 0);
      // sweep of offsets
      cwr(12'h000, 1);
      for (int o = 1; o <= 6; o++) begin
         c = cnt;
         cwr(12'h008, o);
         for (int k = 1; k <= 2*o + 2; k++) begin
            tick(1);
            chk("R5 sweep st1", stage1_o, (cnt >= c + o) ? 1 : 0);
            chk("R6 sweep st2", stage2_o, (cnt >= c + 2*o) ? 1 : 0);
         end
      end
      // R4 carry across word boundary
      cnt = 64'h0000_0000_FFFF_FFFE;
      cwr(12'h008, 4);
      crd(12'h010, d); chk("R4 carry lo", d, 2);
      crd(12'h014, d); chk("R4 carry hi", d, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule